// File: doc/BRIEF.md
# Long-Command Decoder and Responder

This block sits behind a bus receiver that has already framed and CRC-checked an incoming command. Each accepted frame carries an 8-bit data byte, a 4-bit target address and a 4-bit command code, plus a flag telling whether it arrived in one of the long-command formats. The block decodes two commands, format-control register access and byte register read. It qualifies the target address against the programmed device address and handles the broadcast address. It then drives a one-cycle strobe to either the format-control register file or the byte register read port, and hands a 16-bit response word to the transmitter.

A small state machine does the work. Its states are S_IDLE (waiting for a frame), S_DECODE (classifying the latched frame), S_FC_ACC (format-control read or write strobe), S_RR_ACC (register read strobe) and S_RESP (response presented). The transitions are: S_IDLE to S_DECODE on an accepted frame. S_DECODE goes to S_FC_ACC or S_RR_ACC for the two served commands, and back to S_IDLE for dropped or foreign frames. Both access states go to S_RESP when a reply is due. S_FC_ACC goes straight to S_IDLE for a broadcast. S_RESP always returns to S_IDLE. The response format flag is sampled when the frame is accepted, so a reply is carried in the format that was in force before its own write.

Top module: `lcmd_responder`

## Requirements
- R1: After reset no strobe, no response and no foreign-command pulse is asserted, and the block accepts a frame on the first cycle after reset is released.
- R2: A frame whose long-format flag is 0 produces no strobe, no response and no foreign-command pulse.
- R3: A served command (code 4'b1010 or 4'b1011) whose address is neither the programmed address nor 4'b0000 produces no strobe and no response.
- R4: Code 4'b1010 with data bit 7 = 1 pulses fc_wr_en for one cycle with fc_addr = data[6:4] and fc_wdata = data[3:0]. The response is {addr, 4'b0110, 1'b1, data[6:4], data[3:0]}.
- R5: Code 4'b1010 with data bit 7 = 0 pulses fc_rd_en for one cycle with fc_addr = data[6:4]. The response is {addr, 4'b0110, 1'b0, data[6:4], fc_rdata}.
- R6: Code 4'b1011 to the programmed address pulses rr_rd_en for one cycle with rr_addr = data[3:0]. The response is {addr, data[3:0], rr_rdata}.
- R7: Code 4'b1010 sent to address 4'b0000 performs its read or write strobe but produces no response.
- R8: Code 4'b1011 sent to address 4'b0000 produces no strobe and no response.
- R9: Any other code in a long-format frame pulses oth_valid for one cycle with oth_frame = {data, addr, code}, regardless of address, and produces no strobe and no response.
- R10: resp_fmt equals the value of fmt_active on the clock edge that accepted the frame, even when that frame's own write changes fmt_active.
- R11: resp_valid is high for exactly one cycle, in the third cycle after the accepting edge. The strobe comes in the second cycle and a foreign-command pulse in the first.
- R12: A frame_valid pulse arriving while an earlier frame is still being handled is dropped without strobe or response.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_valid | input | 1 | One-cycle pulse: a complete frame is present |
| frame_long | input | 1 | 1 when the frame used a long-command format |
| frame_data | input | 8 | Data byte of the frame |
| frame_addr | input | 4 | Target address field |
| frame_cmd | input | 4 | Command code field |
| dev_addr | input | 4 | Programmed device address |
| fmt_active | input | 1 | Current response-format selection from the register file |
| fc_wr_en | output | 1 | Format-control register write strobe |
| fc_rd_en | output | 1 | Format-control register read strobe |
| fc_addr | output | 3 | Format-control register index |
| fc_wdata | output | 4 | Format-control write nibble |
| fc_rdata | input | 4 | Format-control read nibble, valid while fc_rd_en is high |
| rr_rd_en | output | 1 | Byte register read strobe |
| rr_addr | output | 4 | Byte register address |
| rr_rdata | input | 8 | Byte register data, valid while rr_rd_en is high |
| oth_valid | output | 1 | Foreign-command pulse |
| oth_frame | output | 16 | Foreign frame {data, addr, code} |
| resp_valid | output | 1 | Response word valid for one cycle |
| resp_word | output | 16 | Response word for the transmitter |
| resp_fmt | output | 1 | Format flag to send the response in |

## Verification
Two events meet at one edge: a format-control write that turns the custom format on or off, and the capture of the format flag for the reply to that same command. The bench's register model updates fmt_active on the write strobe. Random and directed writes to index 7 toggle it, and each reply's resp_fmt is judged against the flag the bench held when the frame was sent. A second collision is a new frame_valid while the first is still in S_DECODE. The bench judges it by requiring that exactly one response, the first frame's, comes out of the observation window.

// File: rtl/lcr_pkg.sv
package lcr_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 4;
    localparam int CMD_W  = 4;
    localparam int FA_W   = 3;
    localparam int FD_W   = 4;
    localparam int RA_W   = 4;
    localparam int RD_W   = 8;
    localparam int RESP_W = ADDR_W + 4 + FD_W + FA_W + 1;
    localparam int FRM_W  = DATA_W + ADDR_W + CMD_W;

    localparam logic [CMD_W-1:0]  CMD_FMT_CTRL = 4'b1010;
    localparam logic [CMD_W-1:0]  CMD_REG_READ = 4'b1011;
    localparam logic [ADDR_W-1:0] ADDR_GLOBAL  = '0;
    localparam logic [3:0]        FC_RESP_TAG  = 4'b0110;

    typedef enum logic [2:0] {
        S_IDLE,
        S_DECODE,
        S_FC_ACC,
        S_RR_ACC,
        S_RESP
    } lcr_state_e;

    typedef enum logic [1:0] {
        CLS_DROP,
        CLS_FC,
        CLS_RR,
        CLS_OTHER
    } lcr_cls_e;
endpackage

// File: rtl/lcr_frame_filter.sv
module lcr_frame_filter
    import lcr_pkg::*;
#(
    parameter logic [CMD_W-1:0]  FC_CODE = CMD_FMT_CTRL,
    parameter logic [CMD_W-1:0]  RR_CODE = CMD_REG_READ,
    parameter logic [ADDR_W-1:0] GLB     = ADDR_GLOBAL
) (
    input  logic              is_long,
    input  logic [ADDR_W-1:0] tgt_addr,
    input  logic [CMD_W-1:0]  code,
    input  logic [ADDR_W-1:0] own_addr,
    output lcr_cls_e          cls,
    output logic              bcast
);
    logic to_me;
    logic to_all;

    assign to_all = (tgt_addr == GLB);
    assign to_me  = (tgt_addr == own_addr) && !to_all;

    always_comb begin
        cls   = CLS_DROP;
        bcast = 1'b0;
        if (is_long) begin
            unique case (code)
                FC_CODE: begin
                    if (to_all) begin
                        cls   = CLS_FC;
                        bcast = 1'b1;
                    end else if (to_me) begin
                        cls = CLS_FC;
                    end
                end
                RR_CODE: begin
                    if (to_me) cls = CLS_RR;
                end
                default: cls = CLS_OTHER;
            endcase
        end
    end
endmodule

// File: rtl/lcr_resp_build.sv
module lcr_resp_build
    import lcr_pkg::*;
(
    input  logic              is_fc,
    input  logic [ADDR_W-1:0] tgt_addr,
    input  logic [DATA_W-1:0] data_byte,
    input  logic [FD_W-1:0]   fc_rdata,
    input  logic [RD_W-1:0]   rr_rdata,
    output logic [RESP_W-1:0] word
);
    logic            rw;
    logic [FA_W-1:0] fa;
    logic [FD_W-1:0] fd;

    assign rw = data_byte[DATA_W-1];
    assign fa = data_byte[FD_W +: FA_W];
    assign fd = rw ? data_byte[FD_W-1:0] : fc_rdata;

    always_comb begin
        if (is_fc) word = {tgt_addr, FC_RESP_TAG, rw, fa, fd};
        else       word = {tgt_addr, data_byte[RA_W-1:0], rr_rdata};
    end
endmodule

// File: rtl/lcmd_responder.sv
module lcmd_responder
    import lcr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_valid,
    input  logic              frame_long,
    input  logic [7:0]        frame_data,
    input  logic [3:0]        frame_addr,
    input  logic [3:0]        frame_cmd,
    input  logic [3:0]        dev_addr,
    input  logic              fmt_active,
    output logic              fc_wr_en,
    output logic              fc_rd_en,
    output logic [2:0]        fc_addr,
    output logic [3:0]        fc_wdata,
    input  logic [3:0]        fc_rdata,
    output logic              rr_rd_en,
    output logic [3:0]        rr_addr,
    input  logic [7:0]        rr_rdata,
    output logic              oth_valid,
    output logic [15:0]       oth_frame,
    output logic              resp_valid,
    output logic [15:0]       resp_word,
    output logic              resp_fmt
);
    lcr_state_e        state, state_nx;
    lcr_cls_e          cls;
    logic              bcast;
    logic              f_long;
    logic [DATA_W-1:0] f_data;
    logic [ADDR_W-1:0] f_addr;
    logic [CMD_W-1:0]  f_cmd;
    logic              f_fmt;
    logic              f_bcast;
    logic [RESP_W-1:0] built;
    logic [RESP_W-1:0] resp_q;
    logic              take;

    assign take = frame_valid && (state == S_IDLE);

    lcr_frame_filter u_filter (
        .is_long  (f_long),
        .tgt_addr (f_addr),
        .code     (f_cmd),
        .own_addr (dev_addr),
        .cls      (cls),
        .bcast    (bcast)
    );

    lcr_resp_build u_build (
        .is_fc     (state == S_FC_ACC),
        .tgt_addr  (f_addr),
        .data_byte (f_data),
        .fc_rdata  (fc_rdata),
        .rr_rdata  (rr_rdata),
        .word      (built)
    );

    // Frame and format latch: the format flag is held from acceptance onward
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_long  <= 1'b0;
            f_data  <= '0;
            f_addr  <= '0;
            f_cmd   <= '0;
            f_fmt   <= 1'b0;
            f_bcast <= 1'b0;
            resp_q  <= '0;
        end else begin
            if (take) begin
                f_long <= frame_long;
                f_data <= frame_data;
                f_addr <= frame_addr;
                f_cmd  <= frame_cmd;
                f_fmt  <= fmt_active;
            end
            if (state == S_DECODE) f_bcast <= bcast;
            if (state == S_FC_ACC || state == S_RR_ACC) resp_q <= built;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:   if (frame_valid) state_nx = S_DECODE;
            S_DECODE: begin
                unique case (cls)
                    CLS_FC:  state_nx = S_FC_ACC;
                    CLS_RR:  state_nx = S_RR_ACC;
                    default: state_nx = S_IDLE;
                endcase
            end
            S_FC_ACC: state_nx = f_bcast ? S_IDLE : S_RESP;
            S_RR_ACC: state_nx = S_RESP;
            S_RESP:   state_nx = S_IDLE;
            default:  state_nx = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        fc_wr_en   = (state == S_FC_ACC) &&  f_data[DATA_W-1];
        fc_rd_en   = (state == S_FC_ACC) && !f_data[DATA_W-1];
        fc_addr    = f_data[FD_W +: FA_W];
        fc_wdata   = f_data[FD_W-1:0];
        rr_rd_en   = (state == S_RR_ACC);
        rr_addr    = f_data[RA_W-1:0];
        oth_valid  = (state == S_DECODE) && (cls == CLS_OTHER);
        oth_frame  = {f_data, f_addr, f_cmd};
        resp_valid = (state == S_RESP);
        resp_word  = resp_q;
        resp_fmt   = f_fmt;
    end

    // R11: at most one of strobes, reply and foreign pulse per cycle
    p_one_action_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fc_wr_en, fc_rd_en, rr_rd_en, resp_valid, oth_valid}));

    // R11: a reply always follows an access strobe by one cycle
    p_resp_after_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> $past(fc_wr_en || fc_rd_en || rr_rd_en));

    // R11: reply lasts one cycle
    p_resp_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    // R8: no register read strobe ever targets the broadcast address
    p_rr_not_global_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rr_rd_en |-> (oth_frame[CMD_W +: ADDR_W] != ADDR_GLOBAL));

    // R10: format flag frozen while a frame is in flight
    p_fmt_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_IDLE && state != S_RESP) |=> $stable(resp_fmt));

    // R12: a frame arriving while busy leaves the latched frame untouched
    p_busy_drop_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid && state != S_IDLE) |=> $stable(oth_frame));
endmodule

// File: tb/lcmd_responder_tb.sv
module lcmd_responder_tb_top;
    localparam time CLK_PERIOD = 10ns;
    localparam logic [3:0] DEV = 4'h9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_valid = 1'b0;
    logic        frame_long = 1'b0;
    logic [7:0]  frame_data = '0;
    logic [3:0]  frame_addr = '0;
    logic [3:0]  frame_cmd = '0;
    logic        fmt_active;
    logic        fc_wr_en, fc_rd_en, rr_rd_en, oth_valid, resp_valid, resp_fmt;
    logic [2:0]  fc_addr;
    logic [3:0]  fc_wdata, fc_rdata, rr_addr;
    logic [7:0]  rr_rdata;
    logic [15:0] oth_frame, resp_word;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    logic [3:0] fcm [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    lcmd_responder dut_i (
        .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .frame_long(frame_long),
        .frame_data(frame_data), .frame_addr(frame_addr), .frame_cmd(frame_cmd),
        .dev_addr(DEV), .fmt_active(fmt_active),
        .fc_wr_en(fc_wr_en), .fc_rd_en(fc_rd_en), .fc_addr(fc_addr), .fc_wdata(fc_wdata),
        .fc_rdata(fc_rdata), .rr_rd_en(rr_rd_en), .rr_addr(rr_addr), .rr_rdata(rr_rdata),
        .oth_valid(oth_valid), .oth_frame(oth_frame),
        .resp_valid(resp_valid), .resp_word(resp_word), .resp_fmt(resp_fmt)
    );

    // Bench models of the two register ports
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < 8; k++) fcm[k] <= 4'(k + 1);
            fcm[7] <= 4'h0;
        end else if (fc_wr_en) begin
            fcm[fc_addr] <= fc_wdata;
        end
    end
    assign fc_rdata   = fcm[fc_addr];
    assign fmt_active = (fcm[7] == 4'hF);

    function automatic logic [7:0] rr_model(input logic [3:0] a);
        return {a, ~a} ^ 8'h5A;
    endfunction
    assign rr_rdata = rr_model(rr_addr);

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Expected classification: 0 drop, 1 fc, 2 rr, 3 other
    function automatic int exp_kind(input logic lng, input logic [3:0] a, input logic [3:0] c);
        if (!lng) return 0;
        if (c == 4'b1010) return (a == 4'h0 || a == DEV) ? 1 : 0;
        if (c == 4'b1011) return (a == DEV) ? 2 : 0;
        return 3;
    endfunction

    task automatic send(input logic lng, input logic [3:0] a, input logic [3:0] c,
                        input logic [7:0] d, input bit busy_hit, input string req);
        int kind;
        bit want_resp;
        logic [15:0] exp_word;
        logic exp_fmt;
        int n_resp = 0, n_wr = 0, n_rd = 0, n_rr = 0, n_oth = 0;
        int resp_at = 0, strobe_at = 0, oth_at = 0;
        logic [15:0] got_word = '0;
        logic got_fmt = 0;
        logic [2:0] got_fa = '0;
        logic [3:0] got_fd = '0, got_ra = '0;
        logic [15:0] got_oth = '0;

        kind = exp_kind(lng, a, c);
        exp_fmt = fmt_active;
        want_resp = (kind == 2) || (kind == 1 && a != 4'h0);
        if (kind == 1)
            exp_word = {a, 4'b0110, d[7], d[6:4], d[7] ? d[3:0] : fcm[d[6:4]]};
        else
            exp_word = {a, d[3:0], rr_model(d[3:0])};

        @(negedge clk);
        frame_valid = 1'b1; frame_long = lng; frame_addr = a; frame_cmd = c; frame_data = d;
        for (int i = 1; i <= 6; i++) begin
            @(negedge clk);
            if (i == 1) begin
                if (busy_hit) begin
                    frame_long = 1'b1; frame_addr = DEV; frame_cmd = 4'b1011;
                    frame_data = 8'h03;
                end else frame_valid = 1'b0;
            end
            if (i == 2) frame_valid = 1'b0;
            if (resp_valid) begin n_resp++; resp_at = i; got_word = resp_word; got_fmt = resp_fmt; end
            if (fc_wr_en) begin n_wr++; strobe_at = i; got_fa = fc_addr; got_fd = fc_wdata; end
            if (fc_rd_en) begin n_rd++; strobe_at = i; got_fa = fc_addr; end
            if (rr_rd_en) begin n_rr++; strobe_at = i; got_ra = rr_addr; end
            if (oth_valid) begin n_oth++; oth_at = i; got_oth = oth_frame; end
        end

        chk(n_resp == (want_resp ? 1 : 0), req, "reply count", n_resp, want_resp);
        chk(n_oth == (kind == 3 ? 1 : 0), (kind == 3) ? "R9" : req, "foreign pulses", n_oth, kind == 3);
        chk(n_wr == ((kind == 1 && d[7]) ? 1 : 0), req, "write strobes", n_wr, kind == 1 && d[7]);
        chk(n_rd == ((kind == 1 && !d[7]) ? 1 : 0), req, "fc read strobes", n_rd, kind == 1 && !d[7]);
        chk(n_rr == (kind == 2 ? 1 : 0), req, "rr strobes", n_rr, kind == 2);
        if (want_resp) begin
            chk(got_word == exp_word, req, "reply word", got_word, exp_word);
            chk(got_fmt == exp_fmt, "R10", "reply format", got_fmt, exp_fmt);
            chk(resp_at == 3, "R11", "reply cycle", resp_at, 3);
        end
        if (kind == 1 || kind == 2) chk(strobe_at == 2, "R11", "strobe cycle", strobe_at, 2);
        if (kind == 1) begin
            chk(got_fa == d[6:4], req, "fc index", got_fa, d[6:4]);
            if (d[7]) chk(got_fd == d[3:0], "R4", "fc write data", got_fd, d[3:0]);
        end
        if (kind == 2) chk(got_ra == d[3:0], "R6", "rr address", got_ra, d[3:0]);
        if (kind == 3) begin
            chk(oth_at == 1, "R11", "foreign cycle", oth_at, 1);
            chk(got_oth == {d, a, c}, "R9", "foreign frame", got_oth, {d, a, c});
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : stim
        logic [3:0] ra, rc;
        logic [7:0] rd;
        logic rl;
        int sel;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk(!fc_wr_en && !fc_rd_en && !rr_rd_en && !resp_valid && !oth_valid,
            "R1", "reset outputs", {fc_wr_en, fc_rd_en, rr_rd_en, resp_valid, oth_valid}, 0);
        rst_n = 1'b1;
        // R1: first frame after reset is served
        send(1, DEV, 4'b1011, 8'h05, 0, "R1");
        send(1, DEV, 4'b1011, 8'h0C, 0, "R6");
        send(0, DEV, 4'b1011, 8'h01, 0, "R2");
        send(0, DEV, 4'b1010, 8'hA5, 0, "R2");
        send(0, DEV, 4'b0011, 8'h11, 0, "R2");
        send(1, 4'h3, 4'b1010, 8'h95, 0, "R3");
        send(1, 4'h3, 4'b1011, 8'h02, 0, "R3");
        send(1, DEV, 4'b1010, 8'hB6, 0, "R4");
        send(1, DEV, 4'b1010, 8'h30, 0, "R5");
        send(1, 4'h0, 4'b1010, 8'hA2, 0, "R7");
        send(1, DEV, 4'b1010, 8'h20, 0, "R7");   // reads back the broadcast write
        send(1, 4'h0, 4'b1010, 8'h10, 0, "R7");
        send(1, 4'h0, 4'b1011, 8'h04, 0, "R8");
        send(1, 4'h4, 4'b0111, 8'h3C, 0, "R9");
        // R10: enabling the custom format replies in the old one, next reply in the new one
        send(1, DEV, 4'b1010, 8'hFF, 0, "R10");
        send(1, DEV, 4'b1010, 8'h70, 0, "R10");
        send(1, DEV, 4'b1010, 8'hF0, 0, "R10");
        send(1, DEV, 4'b1011, 8'h07, 0, "R10");
        // R12: second frame during decode is dropped
        send(1, DEV, 4'b1010, 8'h40, 1, "R12");
        send(1, 4'h5, 4'b0001, 8'h77, 1, "R12");
        for (int n = 0; n < 300; n++) begin
            sel = int'($urandom_range(0, 9));
            rl = (sel != 0);
            sel = int'($urandom_range(0, 3));
            ra = (sel == 0) ? 4'h0 : (sel == 3) ? 4'($urandom) : DEV;
            sel = int'($urandom_range(0, 4));
            rc = (sel < 2) ? 4'b1010 : (sel < 4) ? 4'b1011 : 4'($urandom);
            rd = 8'($urandom);
            send(rl, ra, rc, rd, 0, (rc == 4'b1011) ? "R6" : rd[7] ? "R4" : "R5");
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule